// File: doc/BRIEF.md
# FIFO-Triggered Transmit Start Controller

This block sits between a transmit FIFO and a serial shifter. It decides when a transmission may begin and issues a one-cycle start pulse to the shifter. It then follows the shifter until the last bit has gone out, and reports completion on a status bit. It also drives an interrupt line whose source depends on the same configuration that chooses the start condition.

A 2-bit mode field selects the behaviour. Value 01 is buffer mode and values 10 and 11 are packet mode. Value 00 is treated as disabled. A select bit then chooses the start condition. Depending on mode and select bit, a start is triggered by a non-empty FIFO, by a full FIFO, or by a FIFO byte count that has reached a 6-bit threshold. The FIFO storage and the serializer are outside the block. The block only sees the FIFO count, the empty and full flags, and the shifter's idle level.

Top module: `fifo_tx_launch`

## Requirements
- R1: While `rst` is high and in the cycle after it, `tx_start`, `irq0` and `tx_done` are 0.
- R2: Buffer mode (`data_mode` = 01) with `start_sel` = 0 starts a transmission only when `fifo_full` is 1. A count one below full gives no start.
- R3: Buffer mode with `start_sel` = 1 starts a transmission whenever `fifo_empty` is 0.
- R4: Packet mode (`data_mode` = 10 or 11) with `start_sel` = 1 starts a transmission whenever `fifo_empty` is 0.
- R5: Packet mode with `start_sel` = 0 starts a transmission when `fifo_count` >= `level_thresh`, compared as unsigned values. A threshold of 0 starts a transmission even when the FIFO is empty.
- R6: `irq0` is registered and shows the inputs of the previous cycle. In packet mode with `start_sel` = 0 it carries (`fifo_count` >= `level_thresh`). In every other enabled case it carries `fifo_empty`.
- R7: With `data_mode` = 00 no start is issued and `irq0` is 0.
- R8: `tx_start` is high for exactly one cycle, one cycle after the start condition is seen while idle. No further start is issued until the shifter has gone busy and returned to idle.
- R9: `tx_done` rises in the cycle after `shifter_idle` returns to 1 following a start. It is 0 while the transmission is in progress. It clears in the same cycle that the next `tx_start` is high.
- R10: Changing `data_mode` or `start_sel` during a transmission does not end that transmission. The new setting governs only the next start decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | CNT_W (7) | Bytes currently held in the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no bytes |
| fifo_full | input | 1 | FIFO is at capacity |
| data_mode | input | 2 | 00 disabled, 01 buffer, 1x packet |
| start_sel | input | 1 | 1: start on non-empty; 0: start on full (buffer) or threshold (packet) |
| level_thresh | input | THR_W (6) | Byte-count threshold for packet-mode start |
| shifter_idle | input | 1 | Shifter has no bit left to send |
| tx_start | output | 1 | One-cycle start pulse to the shifter |
| irq0 | output | 1 | Interrupt line, source chosen by mode and select |
| tx_done | output | 1 | Last bit of the current transmission has left the shifter |

## Verification
The hardest situation to reach is a configuration change made while a transmission is in flight. To get there, the stimulus starts a transmission in buffer mode and switches the mode to disabled while the modelled shifter is still busy. It then watches for completion, confirms that the FIFO contents cause no further start, and restores the mode to see a fresh start. A long shifter run with the FIFO kept non-empty shows that a standing start condition does not retrigger before the shifter returns to idle. A zero threshold with an empty FIFO covers the edge of the count comparison.

// File: rtl/txl_pkg.sv
package txl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_t;

  typedef enum logic [1:0] {
    IRQ_NONE  = 2'd0,
    IRQ_EMPTY = 2'd1,
    IRQ_LEVEL = 2'd2
  } irq_src_t;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_BUF = 2'b01;

  function automatic logic is_buf_mode(input logic [1:0] m);
    return m == MODE_BUF;
  endfunction

  function automatic logic is_pkt_mode(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/txl_trigger.sv
module txl_trigger
  import txl_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int THR_W = 6
) (
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic [1:0]       data_mode,
  input  logic             start_sel,
  input  logic [THR_W-1:0] level_thresh,
  output logic             trig_hit,
  output logic             level_met,
  output irq_src_t         irq_src
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_ext;
  logic [CMP_W-1:0] thr_ext;

  assign cnt_ext   = CMP_W'(fifo_count);
  assign thr_ext   = CMP_W'(level_thresh);
  assign level_met = (cnt_ext >= thr_ext);

  always_comb begin
    trig_hit = 1'b0;
    irq_src  = IRQ_NONE;
    if (is_buf_mode(data_mode)) begin
      irq_src  = IRQ_EMPTY;
      trig_hit = start_sel ? !fifo_empty : fifo_full;
    end else if (is_pkt_mode(data_mode)) begin
      if (start_sel) begin
        irq_src  = IRQ_EMPTY;
        trig_hit = !fifo_empty;
      end else begin
        irq_src  = IRQ_LEVEL;
        trig_hit = level_met;
      end
    end
  end

endmodule

// File: rtl/txl_irq.sv
module txl_irq
  import txl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_src_t irq_src,
  input  logic     fifo_empty,
  input  logic     level_met,
  output logic     irq0
);

  logic irq_next;

  always_comb begin
    unique case (irq_src)
      IRQ_EMPTY: irq_next = fifo_empty;
      IRQ_LEVEL: irq_next = level_met;
      default:   irq_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq0 <= 1'b0;
    else     irq0 <= irq_next;
  end

endmodule

// File: rtl/txl_seq.sv
module txl_seq
  import txl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig_hit,
  input  logic shifter_idle,
  output logic tx_start,
  output logic tx_done
);

  tx_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tx_start <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trig_hit) begin
            tx_start <= 1'b1;
            tx_done  <= 1'b0;
            state_q  <= ST_ARM;
          end
        end
        ST_ARM: begin
          // wait for the shifter to pick up the start
          if (!shifter_idle) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (shifter_idle) begin
            tx_done <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fifo_tx_launch.sv
module fifo_tx_launch
  import txl_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic [1:0]       data_mode,
  input  logic             start_sel,
  input  logic [THR_W-1:0] level_thresh,
  input  logic             shifter_idle,
  output logic             tx_start,
  output logic             irq0,
  output logic             tx_done
);

  logic     trig_hit;
  logic     level_met;
  irq_src_t irq_src;

  txl_trigger #(.CNT_W(CNT_W), .THR_W(THR_W)) u_trig (
    .fifo_count   (fifo_count),
    .fifo_empty   (fifo_empty),
    .fifo_full    (fifo_full),
    .data_mode    (data_mode),
    .start_sel    (start_sel),
    .level_thresh (level_thresh),
    .trig_hit     (trig_hit),
    .level_met    (level_met),
    .irq_src      (irq_src)
  );

  txl_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .irq_src    (irq_src),
    .fifo_empty (fifo_empty),
    .level_met  (level_met),
    .irq0       (irq0)
  );

  txl_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .trig_hit     (trig_hit),
    .shifter_idle (shifter_idle),
    .tx_start     (tx_start),
    .tx_done      (tx_done)
  );

endmodule

// File: rtl/txl_checker.sv
module txl_checker #(
  parameter int CNT_W = 7,
  parameter int THR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_empty,
  input logic [1:0]       data_mode,
  input logic             start_sel,
  input logic [THR_W-1:0] level_thresh,
  input logic             shifter_idle,
  input logic             tx_start,
  input logic             irq0,
  input logic             tx_done
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_w;
  logic [CMP_W-1:0] thr_w;
  logic             inflight;

  assign cnt_w = CMP_W'(fifo_count);
  assign thr_w = CMP_W'(level_thresh);

  always_ff @(posedge clk) begin
    if (rst)           inflight <= 1'b0;
    else if (tx_start) inflight <= 1'b1;
    else if (tx_done)  inflight <= 1'b0;
  end

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !inflight);

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !tx_done);

  assert_done_after_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(tx_done)) |-> $past(shifter_idle));

  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(data_mode) == 2'b00) |-> (!tx_start && !irq0));

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(data_mode[1]) && !$past(start_sel))
      |-> (irq0 == ($past(cnt_w) >= $past(thr_w))));

  assert_irq_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(data_mode) == 2'b01 ||
                     ($past(data_mode[1]) && $past(start_sel))))
      |-> (irq0 == $past(fifo_empty)));

endmodule

bind fifo_tx_launch txl_checker #(.CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fifo_count   (fifo_count),
  .fifo_empty   (fifo_empty),
  .data_mode    (data_mode),
  .start_sel    (start_sel),
  .level_thresh (level_thresh),
  .shifter_idle (shifter_idle),
  .tx_start     (tx_start),
  .irq0         (irq0),
  .tx_done      (tx_done)
);

// File: tb/fifo_tx_launch_test.sv
module fifo_tx_launch_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 7;
  localparam int THR_W = 6;
  localparam int DEPTH = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] fifo_count = '0;
  logic             fifo_empty, fifo_full;
  logic [1:0]       data_mode = 2'b00;
  logic             start_sel = 1'b0;
  logic [THR_W-1:0] level_thresh = '0;
  logic             shifter_idle;
  logic             tx_start, irq0, tx_done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int starts = 0;
  int bits_left = 0;
  int ser_len = 6;
  string cur_tag = "R1";

  // reference model state
  int m_phase = 0;
  bit m_start = 0, m_irq = 0, m_done = 0;

  assign fifo_empty   = (fifo_count == 0);
  assign fifo_full    = (int'(fifo_count) == DEPTH);
  assign shifter_idle = (bits_left == 0);

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_tx_launch #(.CNT_W(CNT_W), .THR_W(THR_W)) uut (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .data_mode(data_mode), .start_sel(start_sel),
    .level_thresh(level_thresh), .shifter_idle(shifter_idle),
    .tx_start(tx_start), .irq0(irq0), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // shifter model and behavioural reference, both on the old values
  always @(posedge clk) begin
    bit hit, enabled, lvl;
    if (rst) begin
      bits_left <= 0;
      m_phase <= 0; m_start <= 0; m_irq <= 0; m_done <= 0;
    end else begin
      if (tx_start) bits_left <= ser_len;
      else if (bits_left > 0) bits_left <= bits_left - 1;
      lvl = int'(fifo_count) >= int'(level_thresh);
      enabled = (data_mode != 2'b00);
      if (data_mode == 2'b01) hit = start_sel ? (fifo_count != 0) : (int'(fifo_count) == DEPTH);
      else if (data_mode[1]) hit = start_sel ? (fifo_count != 0) : lvl;
      else hit = 0;
      if (!enabled) m_irq <= 0;
      else if (data_mode[1] && !start_sel) m_irq <= lvl;
      else m_irq <= (fifo_count == 0);
      m_start <= 0;
      if (m_phase == 0 && hit) begin
        m_start <= 1; m_done <= 0; m_phase <= 1;
      end else if (m_phase == 1 && bits_left != 0) begin
        m_phase <= 2;
      end else if (m_phase == 2 && bits_left == 0) begin
        m_done <= 1; m_phase <= 0;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (tx_start) starts++;
    chk(tx_start == m_start, cur_tag, tx_start, m_start, "tx_start");
    chk(irq0 == m_irq, "R6", irq0, m_irq, "irq0");
    chk(tx_done == m_done, "R9", tx_done, m_done, "tx_done");
    if (cycles > 20000) begin
      chk(0, "watchdog", cycles, 20000, "cycle limit");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!tx_done) @(negedge clk);
  endtask

  initial begin
    int s0;
    step(3);
    chk(!tx_start && !irq0 && !tx_done, "R1", {tx_start, irq0, tx_done}, 0, "reset outputs");
    rst = 1'b0;
    step(1);
    chk(!tx_start && !tx_done, "R1", {tx_start, tx_done}, 0, "after reset");

    // R7: disabled mode, full FIFO
    cur_tag = "R7";
    fifo_count = 7'(DEPTH); s0 = starts;
    start_sel = 1; step(6); start_sel = 0; step(6);
    chk(starts == s0, "R7", starts - s0, 0, "starts in mode 00");
    chk(irq0 == 0, "R7", irq0, 0, "irq0 in mode 00");

    // R2: buffer, start on full only
    cur_tag = "R2";
    data_mode = 2'b01; start_sel = 0; fifo_count = 7'(DEPTH - 1); s0 = starts;
    step(8);
    chk(starts == s0, "R2", starts - s0, 0, "starts below full");
    chk(irq0 == 0, "R6", irq0, 0, "irq0 empty flag, non-empty FIFO");
    fifo_count = 7'(DEPTH); step(3);
    chk(starts == s0 + 1, "R2", starts - s0, 1, "start on full");
    fifo_count = 0; wait_done(); step(1);
    chk(tx_done == 1, "R9", tx_done, 1, "done after shifter idle");
    chk(irq0 == 1, "R6", irq0, 1, "irq0 follows empty");

    // R3: buffer, start on non-empty
    cur_tag = "R3";
    start_sel = 1; s0 = starts; fifo_count = 1; step(3);
    chk(starts == s0 + 1, "R3", starts - s0, 1, "start on non-empty");
    chk(tx_done == 0, "R9", tx_done, 0, "done cleared by start");
    fifo_count = 0; wait_done();

    // R4: packet modes 10 and 11, non-empty
    cur_tag = "R4";
    for (int m = 2; m < 4; m++) begin
      data_mode = 2'(m); start_sel = 1; s0 = starts;
      fifo_count = 0; step(4);
      chk(starts == s0, "R4", starts - s0, 0, "no start when empty");
      fifo_count = 2; step(3);
      chk(starts == s0 + 1, "R4", starts - s0, 1, "start on non-empty");
      fifo_count = 0; wait_done(); step(1);
    end

    // R5: packet threshold
    cur_tag = "R5";
    data_mode = 2'b10; start_sel = 0; level_thresh = 20; fifo_count = 19; s0 = starts;
    step(6);
    chk(starts == s0, "R5", starts - s0, 0, "count below threshold");
    chk(irq0 == 0, "R6", irq0, 0, "level flag low");
    fifo_count = 20; step(3);
    chk(starts == s0 + 1, "R5", starts - s0, 1, "count equals threshold");
    fifo_count = 5; wait_done(); step(1);
    level_thresh = 0; fifo_count = 0; s0 = starts; step(3);
    chk(starts == s0 + 1, "R5", starts - s0, 1, "zero threshold, empty FIFO");
    chk(irq0 == 1, "R6", irq0, 1, "level flag at zero threshold");
    level_thresh = 63; wait_done(); step(2);

    // R8: long run with a standing start condition
    cur_tag = "R8";
    data_mode = 2'b01; start_sel = 1; ser_len = 30; fifo_count = 5; s0 = starts;
    step(20);
    chk(starts == s0 + 1, "R8", starts - s0, 1, "single start while busy");
    fifo_count = 0; wait_done(); step(1);
    ser_len = 6;

    // R10: mode change mid-transmission
    cur_tag = "R10";
    fifo_count = 3; s0 = starts; step(4);
    chk(starts == s0 + 1, "R10", starts - s0, 1, "start before change");
    data_mode = 2'b00; wait_done();
    chk(tx_done == 1, "R10", tx_done, 1, "transmission completed after change");
    step(8);
    chk(starts == s0 + 1, "R10", starts - s0, 1, "new mode blocks next start");
    data_mode = 2'b01; step(3);
    chk(starts == s0 + 2, "R10", starts - s0, 2, "restart after restore");
    fifo_count = 0; wait_done(); step(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule